// File: doc/BRIEF.md
# Asynchronous Serial Transmitter

This block turns data words into asynchronous serial frames on one output line. A frame has a low start bit, then the data bits starting with the least significant, then an optional ninth bit, then a high stop bit. The line rests high between frames. Words arrive on a valid/ready input port and go into a one-word holding stage. The holding stage hands its word to a separate shift stage, so the host can queue the next word while the current frame is still being sent.

Bit timing comes from a baud tick. A divider reloads from a programmable divisor, which is either 8 or 16 bits wide. Each bit lasts 16 ticks in normal mode and 4 ticks in high-speed mode. In 9-bit mode the extra bit comes from a side input that is captured together with the data word. A receiver can use that bit to tell address words from data words.

Two status flags report progress: a holding-empty flag, usable as an interrupt request, and a shift-empty flag. The input handshake follows these back-pressure rules:
- A word is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high only while the block is enabled and the holding stage is empty.
- The producer must hold its word and `in_bit9` steady until it is taken.
- Nothing on the data inputs is looked at while `in_ready` is low.

Top module: `serial_tx`

## Requirements
- R1: While reset is asserted and afterwards with `en` low, `txd` is 1, `shift_empty` is 1, `buf_empty` is 0 and `in_ready` is 0.
- R2: When `en` goes high while the holding stage is empty, `buf_empty` and `in_ready` go high in the same cycle, with no clock edge needed. `in_ready` always equals `buf_empty`.
- R3: A word is taken on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle `buf_empty` is 0 until that word moves on. While `in_ready` is 0, `in_valid`, `in_data` and `in_bit9` have no effect on what is sent.
- R4: A held word moves into the shift stage on the first baud tick at which the shift stage is empty. In the cycle after that tick, `txd` is 0 (start bit), `buf_empty` is 1 and `shift_empty` is 0.
- R5: With `nine_mode` = 0 at load time, a frame is 10 bits long: a 0, then `in_data` bits 0 to 7 in that order, then a 1.
- R6: With `nine_mode` = 1 at load time, the frame is 11 bits long. It carries the `in_bit9` value captured with the word between data bit 7 and the stop bit.
- R7: Each bit lasts (D+1)×4 clock cycles when `hs_mode` = 1, and (D+1)×16 clock cycles when `hs_mode` = 0, where D is the divisor.
- R8: D is {`div_hi`,`div_lo`} when `wide_div` = 1. When `wide_div` = 0, D is `div_lo` alone and `div_hi` has no effect.
- R9: A word queued during a frame is sent after that frame's stop bit, starting at most one baud tick after the stop bit ends. Both words reach the line complete and in order.
- R10: When `en` goes low, `buf_empty` and `in_ready` drop in the same cycle. From the next cycle `txd` is 1 and `shift_empty` is 1. The frame in progress and any held word are dropped and never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Transmitter enable; low aborts and flushes |
| hs_mode | input | 1 | 1 = 4 ticks per bit, 0 = 16 ticks per bit |
| wide_div | input | 1 | 1 = 16-bit divisor, 0 = low byte only |
| div_lo | input | DIV_W/2 | Divisor low part |
| div_hi | input | DIV_W/2 | Divisor high part |
| nine_mode | input | 1 | 1 = frames carry a ninth bit |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Holding stage can take a word |
| in_data | input | 8 | Data word |
| in_bit9 | input | 1 | Ninth bit, taken with the data word |
| buf_empty | output | 1 | Holding-empty flag (interrupt request) |
| shift_empty | output | 1 | Shift stage idle |
| txd | output | 1 | Serial output line, idles high |

## Verification
Two situations are hardest to reach from the ports. The first is a word waiting in the holding stage while another frame is on the line. The second is clearing the enable exactly then. The bench reaches the first by queuing a second word as soon as the first word moves out, and by offering a third word while `in_ready` is low to confirm it is ignored. It reaches the second by dropping `en` in the middle of a frame with a word held. It then re-enables and watches the line stay idle, which shows the held word was dropped. Bit widths are measured on frames whose first data bit is 1, so the low period equals exactly one bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned WORD_W  = 8;
  localparam int unsigned OS_FAST = 4;
  localparam int unsigned OS_SLOW = 16;
  localparam int unsigned FRAME_W = WORD_W + 3;

  typedef struct packed {
    logic              ninth;
    logic [WORD_W-1:0] data;
  } txw_t;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               wide,
  input  logic [DIV_W/2-1:0] div_lo,
  input  logic [DIV_W/2-1:0] div_hi,
  output logic               tick
);
  localparam int unsigned HALF = DIV_W / 2;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_val;

  // Narrow mode ignores the upper half entirely.
  always_comb div_val = wide ? {div_hi, div_lo} : {{HALF{1'b0}}, div_lo};

  assign tick = en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!en || tick)    cnt_q <= div_val;
    else                     cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_bit9,
  input  logic              take,
  output logic              in_ready,
  output logic              full,
  output txw_t              word
);
  logic full_q;

  assign in_ready = en && !full_q;
  assign full     = full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word   <= '0;
    end else if (!en) begin
      full_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      full_q     <= 1'b1;
      word.data  <= in_data;
      word.ninth <= in_bit9;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic fast,
  input  logic nine,
  input  logic full,
  input  txw_t word,
  output logic take,
  output logic busy,
  output logic txd
);
  localparam int unsigned BCW = $clog2(FRAME_W + 1);
  localparam int unsigned SCW = $clog2(OS_SLOW);

  logic               busy_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BCW-1:0]     left_q;
  logic [SCW-1:0]     sub_q;
  logic               last_sub;

  assign take = en && tick && full && !busy_q;
  assign busy = busy_q;
  assign txd  = busy_q ? sh_q[0] : 1'b1;

  always_comb
    last_sub = fast ? (sub_q == SCW'(OS_FAST - 1)) : (sub_q == SCW'(OS_SLOW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
    end else if (!en) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      sh_q   <= {1'b1, (nine ? word.ninth : 1'b1), word.data, 1'b0};
      left_q <= nine ? BCW'(FRAME_W) : BCW'(FRAME_W - 1);
      sub_q  <= '0;
    end else if (busy_q && tick) begin
      if (last_sub) begin
        sub_q  <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == BCW'(1)) busy_q <= 1'b0;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import sertx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               hs_mode,
  input  logic               wide_div,
  input  logic [DIV_W/2-1:0] div_lo,
  input  logic [DIV_W/2-1:0] div_hi,
  input  logic               nine_mode,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_data,
  input  logic               in_bit9,
  output logic               buf_empty,
  output logic               shift_empty,
  output logic               txd
);
  logic tick, take, full, busy;
  txw_t word;

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .en(en), .wide(wide_div),
    .div_lo(div_lo), .div_hi(div_hi), .tick(tick)
  );

  sertx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
    .in_data(in_data), .in_bit9(in_bit9), .take(take),
    .in_ready(in_ready), .full(full), .word(word)
  );

  sertx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .fast(hs_mode),
    .nine(nine_mode), .full(full), .word(word), .take(take),
    .busy(busy), .txd(txd)
  );

  assign buf_empty   = in_ready;
  assign shift_empty = !busy;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic in_valid,
  input logic in_ready,
  input logic buf_empty,
  input logic shift_empty,
  input logic txd
);
  // R2: turning the enable on shows an empty holding stage at once
  p_enable_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> buf_empty);

  // R3: an accepted word occupies the holding stage in the next cycle
  p_accept_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !buf_empty);

  // R4: a load puts the start bit on the line
  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> !txd);

  // R5: a frame that finishes normally ended on a high stop bit
  p_stop_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(shift_empty) && $past(en)) |-> $past(txd));

  // R10: once disabled for a cycle, the line is idle and the shifter empty
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (txd && shift_empty));
endmodule

bind serial_tx sertx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
  .in_ready(in_ready), .buf_empty(buf_empty),
  .shift_empty(shift_empty), .txd(txd)
);

// File: tb/sim_serial_tx.sv
`timescale 1ns/1ps
module sim_serial_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, hs_mode = 1'b1, wide_div = 1'b0, nine_mode = 1'b0;
  logic [7:0] div_lo = 8'd1, div_hi = 8'd0;
  logic       in_valid = 1'b0, in_bit9 = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, buf_empty, shift_empty, txd;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .hs_mode(hs_mode), .wide_div(wide_div),
    .div_lo(div_lo), .div_hi(div_hi), .nine_mode(nine_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_bit9(in_bit9), .buf_empty(buf_empty), .shift_empty(shift_empty),
    .txd(txd)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic b9);
    int t = 0;
    @(negedge clk);
    while (!in_ready && t < 50000) begin @(negedge clk); t++; end
    in_valid = 1'b1; in_data = d; in_bit9 = b9;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_fall(output bit seen);
    int t = 0;
    seen = 1'b0;
    @(negedge clk);
    while (txd && t < 50000) begin @(negedge clk); t++; end
    seen = !txd;
  endtask

  task automatic rx(input bit nine, input int blen, output logic [8:0] got, output bit frame_ok);
    bit seen;
    got = '0;
    wait_fall(seen);
    repeat (blen/2) @(negedge clk);
    frame_ok = seen && !txd;
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      repeat (blen) @(negedge clk);
      got[i] = txd;
    end
    repeat (blen) @(negedge clk);
    frame_ok = frame_ok && txd;
  endtask

  task automatic wait_idle();
    int t = 0;
    @(negedge clk);
    while (!shift_empty && t < 50000) begin @(negedge clk); t++; end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd in reset", txd, 1);
    chk(shift_empty == 1'b1, "R1 shift_empty in reset", shift_empty, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(buf_empty == 1'b0, "R1 buf_empty disabled", buf_empty, 0);
    chk(in_ready == 1'b0, "R1 in_ready disabled", in_ready, 0);
  endtask

  task automatic t_enable();
    @(negedge clk);
    en = 1'b1;
    #1;
    chk(buf_empty == 1'b1, "R2 flag same cycle", buf_empty, 1);
    chk(in_ready == buf_empty, "R2 ready equals flag", in_ready, buf_empty);
  endtask

  task automatic t_frame8();
    logic [8:0] got; bit ok; bit seen;
    hs_mode = 1'b1; div_lo = 8'd1; nine_mode = 1'b0;
    fork
      rx(1'b0, 8, got, ok);
      begin
        push(8'hA5, 1'b0);
        #1 chk(buf_empty == 1'b0, "R3 held after accept", buf_empty, 0);
      end
    join
    chk(got[7:0] == 8'hA5, "R5 8-bit data", got[7:0], 8'hA5);
    chk(ok, "R5 start/stop levels", ok, 1);
    wait_idle();
    push(8'h0F, 1'b0);
    wait_fall(seen);
    chk(buf_empty == 1'b1, "R4 flag set at load", buf_empty, 1);
    chk(shift_empty == 1'b0, "R4 shifter busy at load", shift_empty, 0);
    wait_idle();
  endtask

  task automatic t_frame9();
    logic [8:0] got; bit ok;
    nine_mode = 1'b1;
    fork rx(1'b1, 8, got, ok); push(8'h3C, 1'b1); join
    chk(got == 9'h13C, "R6 ninth bit one", got, 9'h13C);
    chk(ok, "R6 stop after ninth", ok, 1);
    wait_idle();
    fork rx(1'b1, 8, got, ok); push(8'hC3, 1'b0); join
    chk(got == 9'h0C3, "R6 ninth bit zero", got, 9'h0C3);
    wait_idle();
    nine_mode = 1'b0;
  endtask

  task automatic measure(input int exp, input string req);
    bit seen; int n = 0;
    wait_idle();
    push(8'h01, 1'b0);
    wait_fall(seen);
    while (!txd && n < 5000) begin n++; @(negedge clk); end
    chk(n == exp, req, n, exp);
    wait_idle();
  endtask

  task automatic t_width();
    hs_mode = 1'b0; div_lo = 8'd0; wide_div = 1'b0;
    measure(16, "R7 normal speed D=0");
    hs_mode = 1'b1; div_lo = 8'd2;
    measure(12, "R7 high speed D=2");
    wide_div = 1'b1; div_hi = 8'd1; div_lo = 8'd0;
    measure(1028, "R8 wide divisor D=256");
    wide_div = 1'b0; div_hi = 8'd1; div_lo = 8'd1;
    measure(8, "R8 high byte ignored");
    div_hi = 8'd0;
  endtask

  task automatic t_b2b();
    logic [8:0] ga, gb; bit oka, okb; int t;
    hs_mode = 1'b1; div_lo = 8'd1; nine_mode = 1'b0;
    fork
      begin rx(1'b0, 8, ga, oka); rx(1'b0, 8, gb, okb); end
      begin
        push(8'h96, 1'b0);
        push(8'h5B, 1'b0);
        #1 chk(in_ready == 1'b0, "R9 second word held", in_ready, 0);
        in_valid = 1'b1; in_data = 8'hFF; in_bit9 = 1'b1;
        repeat (10) @(negedge clk);
        in_valid = 1'b0;
      end
    join
    chk(ga[7:0] == 8'h96 && oka, "R9 first frame", ga[7:0], 8'h96);
    chk(gb[7:0] == 8'h5B && okb, "R9 queued frame", gb[7:0], 8'h5B);
    t = 0;
    repeat (300) begin @(negedge clk); if (!txd) t++; end
    chk(t == 0, "R3 word offered while not ready ignored", t, 0);
  endtask

  task automatic t_abort();
    logic [8:0] got; bit ok, seen; int t;
    push(8'h81, 1'b0);
    wait_fall(seen);
    push(8'h22, 1'b0);
    repeat (20) @(negedge clk);
    en = 1'b0;
    #1;
    chk(buf_empty == 1'b0 && in_ready == 1'b0, "R10 flag drops same cycle", buf_empty, 0);
    @(negedge clk);
    chk(txd == 1'b1, "R10 line idle next cycle", txd, 1);
    chk(shift_empty == 1'b1, "R10 shifter empty", shift_empty, 1);
    @(negedge clk);
    en = 1'b1;
    t = 0;
    repeat (200) begin @(negedge clk); if (!txd) t++; end
    chk(t == 0, "R10 held word dropped", t, 0);
    chk(buf_empty == 1'b1, "R10 flag back after enable", buf_empty, 1);
    fork rx(1'b0, 8, got, ok); push(8'h5A, 1'b0); join
    chk(got[7:0] == 8'h5A && ok, "R10 clean frame after abort", got[7:0], 8'h5A);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_frame8();
    t_frame9();
    t_width();
    t_b2b();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule